// File: doc/BRIEF.md
# PC-relative short immediate address unit

This block is the operand and address stage of a small 32-bit processor. For each valid operation it forms a register result from the register value, a 9-bit immediate and the 20-bit program counter. It also forms a next-PC value for a jump taken relative to a register. Move, add and subtract with an immediate, and a new address-load that yields PC plus or minus the immediate, all go through one shared 32-bit adder. The operands of that adder are selected by opcode. A separate 20-bit adder serves the relative jump.

The address-load lets code reach any address within 511 of the current PC with a single short instruction, anywhere in the 1M address space. The PC supplies the upper address bits. A mode input selects a cheaper variant that splices the immediate into the low 9 PC bits instead of adding. That result depends on where the code sits relative to a 512-address boundary. All outputs are registered one cycle after the input is presented.

Top module: `sia_unit`

## Requirements
- R1: While rst_n is low and after the first rising clock edge, wr_en and jmp_taken are 0, and wr_data and npc are 0.
- R2: Opcode 0 (move) with in_vld high gives, on the next clock edge, wr_en=1 and wr_data equal to imm zero-extended to 32 bits.
- R3: Opcode 1 (add) gives wr_en=1 and wr_data=(reg_val+imm) mod 2^32 on the next edge.
- R4: Opcode 2 (subtract) gives wr_en=1 and wr_data=(reg_val-imm) mod 2^32 on the next edge.
- R5: Opcode 3 (relative jump) gives, on the next edge, jmp_taken=1, wr_en=0 and npc=(pc+reg_val) mod 2^20, with reg_val read as signed. Only its low 20 bits matter.
- R6: Opcode 4 (address-load plus) with mode_splice=0 gives wr_en=1 and wr_data={12'b0, (pc+imm) mod 2^20}.
- R7: Opcode 5 (address-load minus) with mode_splice=0 gives wr_en=1 and wr_data={12'b0, (pc-imm) mod 2^20}.
- R8: With mode_splice=1, opcodes 4 and 5 both give wr_data={12'b0, pc[19:9], imm}. Opcodes 0 to 3 are not affected by mode_splice.
- R9: Opcodes 6 and 7, and any cycle with in_vld low, give wr_en=0 and jmp_taken=0 on the next edge. wr_en and jmp_taken are one-cycle pulses, one per valid input.
- R10: npc changes only on the edge that registers a valid opcode 3. Otherwise it holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| in_vld | input | 1 | Operation inputs are valid this cycle |
| op | input | 3 | Operation select (0 move, 1 add, 2 sub, 3 jump, 4 load plus, 5 load minus) |
| mode_splice | input | 1 | 1: address-loads splice imm into the low PC bits |
| pc | input | 20 | Current program counter |
| reg_val | input | 32 | Register operand |
| imm | input | 9 | Short immediate |
| wr_en | output | 1 | Register write enable, one cycle after a writing operation |
| wr_data | output | 32 | Register write value |
| jmp_taken | output | 1 | Relative jump taken, one cycle after a jump |
| npc | output | 20 | Next program counter for the relative jump |

## Verification
The bench targets wrap-around at both ends of the 20-bit address space. A load-plus near the top must come out small, and a load-minus near zero must come out near the top. A design that carried into bit 20, or kept the upper 12 bits, would show nonzero upper bits there. A backward jump with a negative register and a 32-bit add or subtract that overflows are also driven; a design that zero-extended the register, or got the sign wrong, would land on the wrong npc. Splice mode is run at a PC where add and splice give different answers, so a design that mixed them up is seen. A reserved opcode and idle cycles are also driven, and a design that wrote, jumped or disturbed npc on them would be caught.

// File: rtl/sia_pkg.sv
// Shared opcode encoding for the short immediate address unit.
// Assumes a 3-bit operation select decoded upstream.
package sia_pkg;
    typedef enum logic [2:0] {
        OP_MOVI  = 3'd0,
        OP_ADDI  = 3'd1,
        OP_SUBI  = 3'd2,
        OP_JREL  = 3'd3,
        OP_LDAP  = 3'd4,
        OP_LDAM  = 3'd5,
        OP_RSV6  = 3'd6,
        OP_RSV7  = 3'd7
    } sia_op_e;
endpackage

// File: rtl/sia_adder.sv
// Plain W-bit adder with carry-in. Shared by several operations.
// Assumes callers form subtraction as a + ~b + 1.
module sia_adder #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    output logic [W-1:0] sum
);
    // Sum of the two operands and the carry-in, modulo 2^W.
    always_comb begin
        sum = a + b + W'(cin);
    end
endmodule

// File: rtl/sia_opsel.sv
// Operand selector for the shared data adder. It places reg or zero-extended
// PC on side A and the immediate, or its inverse, on side B.
// Assumes ADDR_W <= DATA_W and IMM_W <= ADDR_W.
module sia_opsel
    import sia_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 20,
    parameter int IMM_W  = 9
) (
    input  sia_op_e           op,
    input  logic [ADDR_W-1:0] pc,
    input  logic [DATA_W-1:0] reg_val,
    input  logic [IMM_W-1:0]  imm,
    output logic [DATA_W-1:0] opa,
    output logic [DATA_W-1:0] opb,
    output logic              cin
);
    localparam int PC_PAD = DATA_W - ADDR_W;

    logic [DATA_W-1:0] imm_ext;
    logic [DATA_W-1:0] pc_ext;

    // Zero-extend the immediate and the PC to data width.
    always_comb begin
        imm_ext = DATA_W'(imm);
        pc_ext  = {{PC_PAD{1'b0}}, pc};
    end

    // Pick adder operands by opcode; subtraction uses inverse plus carry.
    always_comb begin
        opa = '0;
        opb = imm_ext;
        cin = 1'b0;
        unique case (op)
            OP_MOVI: begin opa = '0;      opb = imm_ext;  cin = 1'b0; end
            OP_ADDI: begin opa = reg_val; opb = imm_ext;  cin = 1'b0; end
            OP_SUBI: begin opa = reg_val; opb = ~imm_ext; cin = 1'b1; end
            OP_LDAP: begin opa = pc_ext;  opb = imm_ext;  cin = 1'b0; end
            OP_LDAM: begin opa = pc_ext;  opb = ~imm_ext; cin = 1'b1; end
            default: begin opa = '0;      opb = '0;       cin = 1'b0; end
        endcase
    end
endmodule

// File: rtl/sia_unit.sv
// Operand and address stage: immediate move/add/sub, a relative jump by a
// signed register, and PC +/- immediate address-loads, all registered one
// cycle after in_vld. Assumes ADDR_W <= DATA_W and IMM_W <= ADDR_W.
module sia_unit
    import sia_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 20,
    parameter int IMM_W  = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_vld,
    input  logic [2:0]        op,
    input  logic              mode_splice,
    input  logic [ADDR_W-1:0] pc,
    input  logic [DATA_W-1:0] reg_val,
    input  logic [IMM_W-1:0]  imm,
    output logic              wr_en,
    output logic [DATA_W-1:0] wr_data,
    output logic              jmp_taken,
    output logic [ADDR_W-1:0] npc
);
    localparam int PAD_W = DATA_W - ADDR_W;
    localparam int HI_W  = ADDR_W - IMM_W;

    sia_op_e           op_e;
    logic [DATA_W-1:0] opa, opb, dsum;
    logic              cin;
    logic [ADDR_W-1:0] jsum;
    logic [DATA_W-1:0] res_d;
    logic              wr_d;
    logic              jmp_d;

    // Map the raw select onto the shared opcode type.
    always_comb begin
        op_e = sia_op_e'(op);
    end

    sia_opsel #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .IMM_W(IMM_W)) u_sel (
        .op(op_e), .pc(pc), .reg_val(reg_val), .imm(imm),
        .opa(opa), .opb(opb), .cin(cin)
    );

    sia_adder #(.W(DATA_W)) u_dadd (
        .a(opa), .b(opb), .cin(cin), .sum(dsum)
    );

    sia_adder #(.W(ADDR_W)) u_jadd (
        .a(pc), .b(reg_val[ADDR_W-1:0]), .cin(1'b0), .sum(jsum)
    );

    // Choose the register result and the write/jump intents by opcode.
    always_comb begin
        res_d = '0;
        wr_d  = 1'b0;
        jmp_d = 1'b0;
        unique case (op_e)
            OP_MOVI, OP_ADDI, OP_SUBI: begin
                res_d = dsum;
                wr_d  = 1'b1;
            end
            OP_LDAP, OP_LDAM: begin
                if (mode_splice)
                    res_d = {{PAD_W{1'b0}}, pc[ADDR_W-1:IMM_W], imm};
                else
                    res_d = {{PAD_W{1'b0}}, dsum[ADDR_W-1:0]};
                wr_d = 1'b1;
            end
            OP_JREL: jmp_d = 1'b1;
            default: ;
        endcase
    end

    // Register outputs; pulses last one cycle, npc holds unless a jump.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_en     <= 1'b0;
            wr_data   <= '0;
            jmp_taken <= 1'b0;
            npc       <= '0;
        end else begin
            wr_en     <= in_vld && wr_d;
            jmp_taken <= in_vld && jmp_d;
            if (in_vld && wr_d)
                wr_data <= res_d;
            if (in_vld && jmp_d)
                npc <= jsum;
        end
    end
endmodule

// File: rtl/sia_unit_chk.sv
// Property checker for sia_unit, attached by bind. Assumes the same
// parameters as the unit it watches.
module sia_unit_chk #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 20,
    parameter int IMM_W  = 9
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_vld,
    input logic [2:0]        op,
    input logic              mode_splice,
    input logic [ADDR_W-1:0] pc,
    input logic [IMM_W-1:0]  imm,
    input logic              wr_en,
    input logic [DATA_W-1:0] wr_data,
    input logic              jmp_taken,
    input logic [ADDR_W-1:0] npc
);
    localparam int PAD_W = DATA_W - ADDR_W;

    // R2
    movi_val_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && op == 3'd0) |=> (wr_en && wr_data == DATA_W'($past(imm))));

    // R5
    jrel_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && op == 3'd3) |=> (jmp_taken && !wr_en));

    // R6
    lda_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && (op == 3'd4 || op == 3'd5)) |=> (wr_data[DATA_W-1:ADDR_W] == PAD_W'(0)));

    // R8
    splice_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && mode_splice && (op == 3'd4 || op == 3'd5)) |=>
        (wr_data[IMM_W-1:0] == $past(imm) && wr_data[ADDR_W-1:IMM_W] == $past(pc[ADDR_W-1:IMM_W])));

    // R9
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_vld || op == 3'd6 || op == 3'd7) |=> (!wr_en && !jmp_taken));

    // R9
    excl_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && jmp_taken));

    // R10
    npc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_vld && op == 3'd3) |=> $stable(npc));
endmodule

bind sia_unit sia_unit_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .IMM_W(IMM_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .op(op), .mode_splice(mode_splice),
    .pc(pc), .imm(imm), .wr_en(wr_en), .wr_data(wr_data),
    .jmp_taken(jmp_taken), .npc(npc)
);

// File: tb/sim_sia_unit.sv
`timescale 1ns/1ps
module sim_sia_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_vld = 1'b0;
    logic [2:0]  op = 3'd0;
    logic        mode_splice = 1'b0;
    logic [19:0] pc = '0;
    logic [31:0] reg_val = '0;
    logic [8:0]  imm = '0;
    logic        wr_en, jmp_taken;
    logic [31:0] wr_data;
    logic [19:0] npc;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    sia_unit u0 (
        .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .op(op), .mode_splice(mode_splice),
        .pc(pc), .reg_val(reg_val), .imm(imm), .wr_en(wr_en), .wr_data(wr_data),
        .jmp_taken(jmp_taken), .npc(npc)
    );

    always #5 clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Present one operation for one cycle; return with the registered result visible.
    task automatic issue(input logic [2:0] o, input logic [19:0] p, input logic [31:0] r,
                         input logic [8:0] i, input logic sp);
        @(negedge clk);
        in_vld = 1'b1; op = o; pc = p; reg_val = r; imm = i; mode_splice = sp;
        @(negedge clk);
        in_vld = 1'b0;
    endtask

    task automatic t_reset;
        chk("R1 wr_en", 32'(wr_en), 0);
        chk("R1 jmp_taken", 32'(jmp_taken), 0);
        chk("R1 wr_data", wr_data, 0);
        chk("R1 npc", 32'(npc), 0);
    endtask

    task automatic t_move;
        issue(3'd0, 20'h12345, 32'hDEADBEEF, 9'h1FF, 1'b0);
        chk("R2 wr_en", 32'(wr_en), 1);
        chk("R2 data 1FF", wr_data, 32'h1FF);
        issue(3'd0, 20'h0, 32'hFFFFFFFF, 9'h000, 1'b1);
        chk("R2 data 0", wr_data, 32'h0);
    endtask

    task automatic t_addsub;
        issue(3'd1, 20'h0, 32'hFFFFFFFF, 9'h001, 1'b0);
        chk("R3 wrap", wr_data, 32'h0);
        issue(3'd1, 20'h0, 32'h0000_1000, 9'h0AB, 1'b1);
        chk("R3 splice ignored", wr_data, 32'h0000_10AB);
        chk("R3 wr_en", 32'(wr_en), 1);
        issue(3'd2, 20'h0, 32'h0, 9'h001, 1'b0);
        chk("R4 wrap", wr_data, 32'hFFFFFFFF);
        issue(3'd2, 20'h0, 32'h0001_0000, 9'h100, 1'b0);
        chk("R4 value", wr_data, 32'h0000_FF00);
    endtask

    task automatic t_jump;
        logic [31:0] keep;
        keep = wr_data;
        issue(3'd3, 20'h00100, 32'h0000_0040, 9'h0, 1'b0);
        chk("R5 taken", 32'(jmp_taken), 1);
        chk("R5 no write", 32'(wr_en), 0);
        chk("R5 npc fwd", 32'(npc), 32'h00140);
        chk("R5 data kept", wr_data, keep);
        issue(3'd3, 20'h00005, 32'hFFFF_FFF0, 9'h0, 1'b0);
        chk("R5 npc back wrap", 32'(npc), 32'h FFFF5);
    endtask

    task automatic t_lda;
        issue(3'd4, 20'hFFFFF, 32'hAAAA_5555, 9'h003, 1'b0);
        chk("R6 top wrap", wr_data, 32'h0000_0002);
        issue(3'd4, 20'h12345, 32'h0, 9'h0AB, 1'b0);
        chk("R6 add", wr_data, 32'h0001_23F0);
        issue(3'd5, 20'h00002, 32'hFFFF_FFFF, 9'h005, 1'b0);
        chk("R7 zero wrap", wr_data, 32'h000F_FFFD);
        issue(3'd5, 20'h12345, 32'h0, 9'h1FF, 1'b0);
        chk("R7 sub", wr_data, 32'h0001_2146);
    endtask

    task automatic t_splice;
        issue(3'd4, 20'h12345, 32'h0, 9'h0AB, 1'b1);
        chk("R8 plus", wr_data, 32'h0001_22AB);
        issue(3'd5, 20'hFFFFF, 32'h0, 9'h001, 1'b1);
        chk("R8 minus", wr_data, 32'h000F_FE01);
    endtask

    task automatic t_quiet;
        logic [19:0] npc_keep;
        npc_keep = npc;
        issue(3'd6, 20'h00100, 32'h1, 9'h1, 1'b0);
        chk("R9 op6 no write", 32'(wr_en), 0);
        chk("R9 op6 no jump", 32'(jmp_taken), 0);
        chk("R10 op6 npc", 32'(npc), 32'(npc_keep));
        issue(3'd7, 20'h00200, 32'h2, 9'h2, 1'b0);
        chk("R9 op7 no write", 32'(wr_en), 0);
        issue(3'd0, 20'h00300, 32'h3, 9'h7, 1'b0);
        chk("R10 move npc", 32'(npc), 32'(npc_keep));
        @(negedge clk);
        chk("R9 pulse ends", 32'(wr_en), 0);
        issue(3'd3, 20'h00010, 32'h1, 9'h0, 1'b0);
        @(negedge clk);
        chk("R9 jump pulse ends", 32'(jmp_taken), 0);
        chk("R10 npc held idle", 32'(npc), 32'h00011);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_move();
        t_addsub();
        t_jump();
        t_lda();
        t_splice();
        t_quiet();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule